// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous binary up-counter with a parallel preset. Every bit of the count register updates on the rising edge of one shared clock, so all output bits change together. An active-low clear empties the register at once, without waiting for a clock edge. An active-low load copies a data word into the register at the next edge. Two active-high enables must both be high for the register to advance by one.

Only the second enable, the carry enable, also gates the carry output. The carry output is combinational and is high when the count is at its maximum and the carry enable is high. To chain stages, drive a higher stage's carry enable from the lower stage's carry output and share the clock, load and count enable between them. The higher stage then advances only on the edge where the lower stage wraps. The width is a parameter and defaults to four bits.

Top module: `sync_preset_counter`

## Requirements
- R1: While `arst_n` is low, `count` is 0 immediately, without any clock edge. This holds even when `ld_n` is low at the same time.
- R2: With `arst_n` high and `ld_n` low, `count` takes the value of `din` at the next rising edge, whatever `cnt_en` and `carry_en` are.
- R3: With `arst_n` and `ld_n` high, and `cnt_en` and `carry_en` both high, `count` rises by exactly one at each rising edge.
- R4: With `arst_n` and `ld_n` high, and either enable low, `count` keeps its value across rising edges.
- R5: `carry_out` is high exactly when `carry_en` is high and `count` is all ones (15 for the default width). It follows `carry_en` in the same cycle, with no clock delay.
- R6: Counting is plain binary: from all ones, an increment edge gives 0.
- R7: Only the values of the enables at the rising edge matter. Pulses on the enables between edges have no effect on `count`.
- R8: Two stages chained through carry output to carry enable form one wider counter. The upper stage advances only on the edge where the lower stage wraps from all ones to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| arst_n | input | 1 | Asynchronous clear, active low, highest priority |
| ld_n | input | 1 | Synchronous parallel preset, active low |
| cnt_en | input | 1 | Count enable that does not affect the carry |
| carry_en | input | 1 | Count enable that also gates `carry_out` |
| din | input | W (4) | Preset value |
| count | output | W (4) | Current count |
| carry_out | output | 1 | Terminal-count carry, combinational |

## Verification
On every cycle, the assertions check the following relations:
- the result of a load;
- the increment, including the wrap from all ones to 0;
- the hold when an enable is low;
- the zero while clear is active;
- the two implications that tie `carry_out` to `carry_en` and to a full count.

Other behaviour shows up only in the bench scenarios:
- the clear taking effect between clock edges;
- pulses on the enables between edges being ignored;
- the full preset-and-count sequence;
- the carry propagating through a two-stage chain.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
    localparam int unsigned DEF_W = 4;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_INC  = 2'd2
    } ctr_op_e;
endpackage

// File: rtl/ctr_op_decode.sv
module ctr_op_decode
    import ctr_pkg::*;
(
    input  logic    ld_n,
    input  logic    cnt_en,
    input  logic    carry_en,
    output ctr_op_e op
);
    always_comb begin
        if (!ld_n)
            op = OP_LOAD;
        else if (cnt_en && carry_en)
            op = OP_INC;
        else
            op = OP_HOLD;
    end
endmodule

// File: rtl/ctr_carry.sv
module ctr_carry #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] value,
    input  logic         carry_en,
    output logic         carry_out
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_comb begin
        carry_out = carry_en && (value == TOP);
    end
endmodule

// File: rtl/sync_preset_counter.sv
module sync_preset_counter
    import ctr_pkg::*;
#(
    parameter int unsigned W = DEF_W
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic         ld_n,
    input  logic         cnt_en,
    input  logic         carry_en,
    input  logic [W-1:0] din,
    output logic [W-1:0] count,
    output logic         carry_out
);
    localparam logic [W-1:0] ONE    = W'(1);
    localparam logic [W-1:0] ALL_HI = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] value;
    } ctr_state_t;

    ctr_state_t state_d, state_q;
    ctr_op_e    op;

    ctr_op_decode u_dec (
        .ld_n     (ld_n),
        .cnt_en   (cnt_en),
        .carry_en (carry_en),
        .op       (op)
    );

    always_comb begin
        state_d = state_q;
        unique case (op)
            OP_LOAD: state_d.value = din;
            OP_INC:  state_d.value = state_q.value + ONE;
            default: state_d.value = state_q.value;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign count = state_q.value;

    ctr_carry #(.W(W)) u_carry (
        .value     (state_q.value),
        .carry_en  (carry_en),
        .carry_out (carry_out)
    );

    // R1: while clear is held, the register reads zero
    assert_clear_zero_R1: assert property (@(posedge clk)
        !arst_n |-> count == '0);

    // R2: a load wins over both enables
    assert_load_R2: assert property (@(posedge clk) disable iff (!arst_n)
        !ld_n |=> count == $past(din));

    // R3: increment by exactly one
    assert_inc_R3: assert property (@(posedge clk) disable iff (!arst_n)
        (ld_n && cnt_en && carry_en) |=> count == W'($past(count) + ONE));

    // R4: either enable low holds the value
    assert_hold_R4: assert property (@(posedge clk) disable iff (!arst_n)
        (ld_n && !(cnt_en && carry_en)) |=> $stable(count));

    // R5: the carry requires a full count
    assert_carry_full_R5: assert property (@(posedge clk) disable iff (!arst_n)
        carry_out |-> count == ALL_HI);

    // R5: the carry is gated by the carry enable
    assert_carry_gate_R5: assert property (@(posedge clk) disable iff (!arst_n)
        !carry_en |-> !carry_out);

    // R6: wrap from all ones to zero
    assert_wrap_R6: assert property (@(posedge clk) disable iff (!arst_n)
        (ld_n && cnt_en && carry_en && count == ALL_HI) |=> count == '0);
endmodule

// File: tb/sync_preset_counter_test.sv
`timescale 1ns/100ps
module sync_preset_counter_test;
    logic       clk = 1'b0;
    logic       arst_n = 1'b0;
    logic       ld_n = 1'b1;
    logic       cnt_en = 1'b0;
    logic       carry_en = 1'b0;
    logic [3:0] din = 4'd0;
    logic [3:0] count;
    logic       carry_out;

    // two-stage chain
    logic       c_ld_n = 1'b1;
    logic       c_en = 1'b0;
    logic       c_t = 1'b0;
    logic [3:0] c_din_lo = 4'd0;
    logic [3:0] c_din_hi = 4'd0;
    logic [3:0] lo_q, hi_q;
    logic       lo_c, hi_c;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sync_preset_counter #(.W(4)) uut (
        .clk(clk), .arst_n(arst_n), .ld_n(ld_n), .cnt_en(cnt_en),
        .carry_en(carry_en), .din(din), .count(count), .carry_out(carry_out)
    );

    sync_preset_counter #(.W(4)) u_lo (
        .clk(clk), .arst_n(arst_n), .ld_n(c_ld_n), .cnt_en(c_en),
        .carry_en(c_t), .din(c_din_lo), .count(lo_q), .carry_out(lo_c)
    );

    sync_preset_counter #(.W(4)) u_hi (
        .clk(clk), .arst_n(arst_n), .ld_n(c_ld_n), .cnt_en(c_en),
        .carry_en(lo_c), .din(c_din_hi), .count(hi_q), .carry_out(hi_c)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one clock edge, then sample at the following falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        arst_n = 1'b0;
        step();
        chk("R1 reset count", count, 0);
        chk("R5 reset carry", carry_out, 0);
        arst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_preset_sequence();
        int seq[6] = '{13, 14, 15, 0, 1, 2};
        ld_n = 1'b0; din = 4'd12; cnt_en = 1'b0; carry_en = 1'b0;
        step();
        chk("R2 load ignores enables", count, 12);
        ld_n = 1'b1; cnt_en = 1'b1; carry_en = 1'b1;
        foreach (seq[i]) begin
            step();
            chk("R3 R6 count sequence", count, seq[i]);
            if (seq[i] == 15) chk("R5 carry at full", carry_out, 1);
            else chk("R5 carry low", carry_out, 0);
        end
        cnt_en = 1'b0;
        step(); step();
        chk("R4 inhibit holds", count, 2);
    endtask

    task automatic t_enable_gating();
        ld_n = 1'b0; din = 4'd15; cnt_en = 1'b1; carry_en = 1'b1;
        step();
        chk("R2 load with enables high", count, 15);
        ld_n = 1'b1; cnt_en = 1'b0; carry_en = 1'b1;
        step();
        chk("R4 cnt_en low holds", count, 15);
        chk("R5 carry high with carry_en", carry_out, 1);
        cnt_en = 1'b1; carry_en = 1'b0;
        #0.5;
        chk("R5 carry drops combinationally", carry_out, 0);
        step();
        chk("R4 carry_en low holds", count, 15);
        carry_en = 1'b1;
        #0.5;
        chk("R5 carry rises combinationally", carry_out, 1);
        step();
        chk("R6 wrap to zero", count, 0);
    endtask

    task automatic t_enable_pulses();
        ld_n = 1'b0; din = 4'd5; cnt_en = 1'b0; carry_en = 1'b1;
        step();
        ld_n = 1'b1;
        // pulse during the low phase, gone before the edge
        #0.5 cnt_en = 1'b1;
        #1   cnt_en = 1'b0;
        @(posedge clk);
        // pulse during the high phase, after the edge
        #0.5 cnt_en = 1'b1;
        #1   cnt_en = 1'b0;
        @(negedge clk);
        chk("R7 between-edge pulses ignored", count, 5);
        step();
        chk("R7 still held", count, 5);
    endtask

    task automatic t_async_clear();
        ld_n = 1'b0; din = 4'd9;
        step();
        ld_n = 1'b1;
        chk("R2 load nine", count, 9);
        #0.5 arst_n = 1'b0;
        #0.5;
        chk("R1 clear without edge", count, 0);
        ld_n = 1'b0; din = 4'd7;
        step();
        chk("R1 clear beats load", count, 0);
        arst_n = 1'b1; ld_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_cascade();
        c_ld_n = 1'b0; c_din_lo = 4'd14; c_din_hi = 4'd3; c_en = 1'b1; c_t = 1'b1;
        step();
        c_ld_n = 1'b1;
        chk("R8 cascade load", {hi_q, lo_q}, 8'h3E);
        step();
        chk("R8 upper waits", {hi_q, lo_q}, 8'h3F);
        chk("R8 low carry out", lo_c, 1);
        step();
        chk("R8 upper advances on wrap", {hi_q, lo_q}, 8'h40);
        step();
        chk("R8 upper steady", {hi_q, lo_q}, 8'h41);
        c_ld_n = 1'b0; c_din_lo = 4'd15; c_din_hi = 4'd15;
        step();
        c_ld_n = 1'b1;
        chk("R8 top carry", hi_c, 1);
        step();
        chk("R8 full wrap", {hi_q, lo_q}, 8'h00);
        c_en = 1'b0;
        step();
        chk("R8 shared enable holds", {hi_q, lo_q}, 8'h00);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_preset_sequence();
        t_enable_gating();
        t_enable_pulses();
        t_async_clear();
        t_cascade();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule